// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Volume and Mute

This block sits on the main stereo output path of an audio/video switching chip and works on signed PCM samples. Each valid sample it picks one of five stereo source lanes, attenuates both channels through a fine step (1 dB granularity) followed by a coarse step (8 dB granularity), optionally doubles the level (+6 dB) with saturation, and can fold the pair down to mono. The processed pair appears one clock later.

Volume and software mute settings can be applied in two ways. With zero-cross gating off, the control inputs seen with a sample govern that sample. With gating on, a changed setting is held back until both channels have crossed zero, so the level step lands where the waveform is small. A timeout forces the setting through if no crossing arrives. A status flag reports that a crossing has happened since gating was enabled. A hardware mute input silences the outputs at once and bypasses all gating.

Top module: `zc_volume_top`

## Requirements
- R1: Source code `src_sel` 0..4 selects lane 0..4 of `in_l`/`in_r` (lane k at bits k*DW upward); codes 5..7 select a zero sample on both channels.
- R2: The fine stage multiplies by a Q1.15 gain chosen by `fine_sel` 0..7 = 32768, 29205, 26029, 23198, 20675, 18427, 16423, 14637, then shifts right arithmetically by 15 (floor). It is applied before the coarse stage.
- R3: The coarse stage then multiplies by a Q1.15 gain chosen by `coarse_sel` 0..7 = 32768, 13045, 5193, 2068, 823, 328, 130, 52 and shifts right arithmetically by 15.
- R4: With `boost_en` = 1 the attenuated value is doubled and saturated to the signed DW range; with 0 it passes unchanged.
- R5: With `mono_en` = 1 both outputs equal floor((left + right) / 2) of the processed channels, summed with one guard bit; with 0 the channels stay separate.
- R6: With `zc_en` = 0, the `coarse_sel`, `fine_sel` and `sw_mute` values presented with a sample apply to that sample and become the active setting; `sw_mute` = 1 gives zero on both channels.
- R7: With `zc_en` = 1, a request differing from the active setting is pending; it commits on the first sample at which each channel has shown a crossing since the request became pending. A crossing is a sign change from the previous selected sample or a magnitude at most ZC_THRESH (default 64). The committing sample already uses the new setting.
- R8: A pending request also commits on the sample at which the number of earlier pending samples equals `timeout_lim`.
- R9: `zc_status` is 0 while `zc_en` = 0; with `zc_en` = 1 it becomes 1 after a sample at which both channels have crossed, and stays 1 while `zc_en` remains 1.
- R10: `hw_mute` = 1 at a clock edge forces both outputs to zero after that edge, with or without a valid sample and regardless of gating.
- R11: `out_valid` follows `in_valid` by one cycle; without a valid sample and without hardware mute the outputs hold.
- R12: Reset clears outputs and status and makes the active setting coarse 0, fine 0, muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_l | input | NSRC*DW | Left samples of all source lanes |
| in_r | input | NSRC*DW | Right samples of all source lanes |
| src_sel | input | SEL_W | Source lane code |
| coarse_sel | input | 3 | Coarse attenuation code |
| fine_sel | input | 3 | Fine attenuation code |
| boost_en | input | 1 | +6 dB stage enable |
| mono_en | input | 1 | Mono fold-down enable |
| sw_mute | input | 1 | Software mute request |
| zc_en | input | 1 | Zero-cross gating enable |
| timeout_lim | input | TO_W | Pending-sample limit before a forced commit |
| hw_mute | input | 1 | Immediate hardware mute |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | DW | Processed left sample |
| out_r | output | DW | Processed right sample |
| zc_status | output | 1 | Zero crossing reached since gating enabled |

## Verification
Every result is due exactly one clock edge after the sample or control change that causes it: data, strobe and status all come from a single register stage, and the hardware mute clears the outputs at the very next edge. Inputs are changed on the falling edge, and the behavioural model in the bench advances on the same rising edge as the design, so its expected values are compared against the outputs at the following falling edge. Directed cases for timeout and crossing commits count samples from the request, so the cycle in which the new gain first shows is pinned exactly.

// File: rtl/avc_pkg.sv
package avc_pkg;

    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 15;

    typedef struct packed {
        logic [2:0] coarse;
        logic [2:0] fine;
        logic       mute;
    } vol_set_t;

    // Q1.15 gains for 0..-7 dB in 1 dB steps
    function automatic logic [GAIN_W-1:0] fine_gain(input logic [2:0] code);
        case (code)
            3'd0:    fine_gain = 16'd32768;
            3'd1:    fine_gain = 16'd29205;
            3'd2:    fine_gain = 16'd26029;
            3'd3:    fine_gain = 16'd23198;
            3'd4:    fine_gain = 16'd20675;
            3'd5:    fine_gain = 16'd18427;
            3'd6:    fine_gain = 16'd16423;
            default: fine_gain = 16'd14637;
        endcase
    endfunction

    // Q1.15 gains for 0..-56 dB in 8 dB steps
    function automatic logic [GAIN_W-1:0] coarse_gain(input logic [2:0] code);
        case (code)
            3'd0:    coarse_gain = 16'd32768;
            3'd1:    coarse_gain = 16'd13045;
            3'd2:    coarse_gain = 16'd5193;
            3'd3:    coarse_gain = 16'd2068;
            3'd4:    coarse_gain = 16'd823;
            3'd5:    coarse_gain = 16'd328;
            3'd6:    coarse_gain = 16'd130;
            default: coarse_gain = 16'd52;
        endcase
    endfunction

endpackage

// File: rtl/avc_zc_detect.sv
module avc_zc_detect #(
    parameter int DW     = 16,
    parameter int THRESH = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic                 keep_flag,
    input  logic signed [DW-1:0] sample,
    output logic                 crossed
);
    localparam logic signed [DW:0] THR_V = (DW+1)'(THRESH);

    logic              prev_neg_q;
    logic              flag_q;
    logic signed [DW:0] ext;
    logic signed [DW:0] mag;
    logic              cross_now;

    always_comb begin
        ext       = {sample[DW-1], sample};
        mag       = ext[DW] ? -ext : ext;
        cross_now = (sample[DW-1] != prev_neg_q) || (mag <= THR_V);
        crossed   = flag_q || cross_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_neg_q <= 1'b0;
            flag_q     <= 1'b0;
        end else if (valid) begin
            prev_neg_q <= sample[DW-1];
            flag_q     <= keep_flag ? crossed : 1'b0;
        end
    end

endmodule

// File: rtl/avc_commit_ctrl.sv
module avc_commit_ctrl
    import avc_pkg::*;
#(
    parameter int TO_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic            zc_en,
    input  vol_set_t        req,
    input  logic            both_crossed,
    input  logic [TO_W-1:0] timeout_lim,
    output vol_set_t        use_set,
    output logic            keep_flags,
    output logic            zc_status
);
    vol_set_t        act_q;
    logic [TO_W-1:0] wait_q;
    logic            pending;
    logic            commit;

    always_comb begin
        pending    = zc_en && (req != act_q);
        commit     = pending && (both_crossed || (wait_q >= timeout_lim));
        use_set    = (!zc_en || commit) ? req : act_q;
        keep_flags = pending && !commit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= '{coarse: 3'd0, fine: 3'd0, mute: 1'b1};
            wait_q    <= '0;
            zc_status <= 1'b0;
        end else begin
            if (valid) begin
                act_q  <= use_set;
                wait_q <= keep_flags ? wait_q + 1'b1 : '0;
            end
            if (!zc_en)
                zc_status <= 1'b0;
            else if (valid && both_crossed)
                zc_status <= 1'b1;
        end
    end

endmodule

// File: rtl/avc_gain_chan.sv
module avc_gain_chan
    import avc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] x,
    input  vol_set_t             vol,
    input  logic                 boost,
    output logic signed [DW-1:0] y
);
    localparam int PW = DW + GAIN_W + 1;
    localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0] p_fine;
    logic signed [PW-1:0] p_coarse;
    logic signed [DW-1:0] a_fine;
    logic signed [DW-1:0] a_coarse;
    logic signed [DW:0]   dbl;

    always_comb begin
        p_fine   = PW'(x) * PW'($signed({1'b0, fine_gain(vol.fine)}));
        a_fine   = DW'(p_fine >>> GAIN_FRAC);
        p_coarse = PW'(a_fine) * PW'($signed({1'b0, coarse_gain(vol.coarse)}));
        a_coarse = DW'(p_coarse >>> GAIN_FRAC);
        dbl      = boost ? {a_coarse, 1'b0} : {a_coarse[DW-1], a_coarse};
        if (vol.mute)
            y = '0;
        else if (dbl[DW] != dbl[DW-1])
            y = dbl[DW] ? S_MIN : S_MAX;
        else
            y = dbl[DW-1:0];
    end

endmodule

// File: rtl/zc_volume_top.sv
module zc_volume_top
    import avc_pkg::*;
#(
    parameter int DW        = 16,
    parameter int NSRC      = 5,
    parameter int SEL_W     = 3,
    parameter int TO_W      = 12,
    parameter int ZC_THRESH = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [NSRC*DW-1:0]     in_l,
    input  logic [NSRC*DW-1:0]     in_r,
    input  logic [SEL_W-1:0]       src_sel,
    input  logic [2:0]             coarse_sel,
    input  logic [2:0]             fine_sel,
    input  logic                   boost_en,
    input  logic                   mono_en,
    input  logic                   sw_mute,
    input  logic                   zc_en,
    input  logic [TO_W-1:0]        timeout_lim,
    input  logic                   hw_mute,
    output logic                   out_valid,
    output logic signed [DW-1:0]   out_l,
    output logic signed [DW-1:0]   out_r,
    output logic                   zc_status
);
    localparam int NCH = 2;

    logic [NSRC*DW-1:0]   ch_in   [NCH];
    logic signed [DW-1:0] sel_x   [NCH];
    logic signed [DW-1:0] gain_y  [NCH];
    logic [NCH-1:0]       crossed;
    logic                 keep_flags;
    vol_set_t             req;
    vol_set_t             use_set;
    logic signed [DW:0]   mix;

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;
    assign req      = '{coarse: coarse_sel, fine: fine_sel, mute: sw_mute};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_comb begin
                sel_x[c] = '0;
                for (int k = 0; k < NSRC; k++)
                    if (src_sel == SEL_W'(k))
                        sel_x[c] = ch_in[c][k*DW +: DW];
            end

            avc_zc_detect #(.DW(DW), .THRESH(ZC_THRESH)) u_zc (
                .clk       (clk),
                .rst       (rst),
                .valid     (in_valid),
                .keep_flag (keep_flags),
                .sample    (sel_x[c]),
                .crossed   (crossed[c])
            );

            avc_gain_chan #(.DW(DW)) u_gain (
                .x     (sel_x[c]),
                .vol   (use_set),
                .boost (boost_en),
                .y     (gain_y[c])
            );
        end
    endgenerate

    avc_commit_ctrl #(.TO_W(TO_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .valid        (in_valid),
        .zc_en        (zc_en),
        .req          (req),
        .both_crossed (&crossed),
        .timeout_lim  (timeout_lim),
        .use_set      (use_set),
        .keep_flags   (keep_flags),
        .zc_status    (zc_status)
    );

    assign mix = {gain_y[0][DW-1], gain_y[0]} + {gain_y[1][DW-1], gain_y[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= in_valid;
            if (hw_mute) begin
                out_l <= '0;
                out_r <= '0;
            end else if (in_valid) begin
                out_l <= mono_en ? DW'(mix >>> 1) : gain_y[0];
                out_r <= mono_en ? DW'(mix >>> 1) : gain_y[1];
            end
        end
    end

endmodule

// File: rtl/avc_chk.sv
module avc_chk #(
    parameter int DW    = 16,
    parameter int NSRC  = 5,
    parameter int SEL_W = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [SEL_W-1:0]     src_sel,
    input logic                 sw_mute,
    input logic                 zc_en,
    input logic                 mono_en,
    input logic                 hw_mute,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_l,
    input logic signed [DW-1:0] out_r,
    input logic                 zc_status
);

    assert_src_mute_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(src_sel) >= NSRC) |=> (out_l == '0 && out_r == '0));

    assert_mono_equal_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mono_en && !hw_mute) |=> (out_l == out_r));

    assert_sw_mute_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !zc_en && sw_mute) |=> (out_l == '0 && out_r == '0));

    assert_status_off_R9: assert property (@(posedge clk) disable iff (rst)
        !zc_en |=> !zc_status);

    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (zc_en && zc_status) |=> zc_status);

    assert_hw_mute_R10: assert property (@(posedge clk) disable iff (rst)
        hw_mute |=> (out_l == '0 && out_r == '0));

    assert_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !hw_mute) |=> ($stable(out_l) && $stable(out_r)));

    assert_reset_R12: assert property (@(posedge clk)
        rst |=> (!out_valid && !zc_status && out_l == '0 && out_r == '0));

endmodule

bind zc_volume_top avc_chk #(.DW(DW), .NSRC(NSRC), .SEL_W(SEL_W)) u_avc_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_sel   (src_sel),
    .sw_mute   (sw_mute),
    .zc_en     (zc_en),
    .mono_en   (mono_en),
    .hw_mute   (hw_mute),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r),
    .zc_status (zc_status)
);

// File: tb/tb_zc_volume_top.sv
module tb_zc_volume_top;
    localparam int DW    = 16;
    localparam int NSRC  = 5;
    localparam int SEL_W = 3;
    localparam int TO_W  = 12;
    localparam int THR   = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] lane_l [NSRC];
    logic signed [DW-1:0] lane_r [NSRC];
    logic [NSRC*DW-1:0]   in_l, in_r;
    logic [SEL_W-1:0]     src_sel = '0;
    logic [2:0]           coarse_sel = '0, fine_sel = '0;
    logic                 boost_en = 1'b0, mono_en = 1'b0, sw_mute = 1'b0;
    logic                 zc_en = 1'b0, hw_mute = 1'b0;
    logic [TO_W-1:0]      timeout_lim = '0;
    logic                 out_valid, zc_status;
    logic signed [DW-1:0] out_l, out_r;

    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            in_l[k*DW +: DW] = lane_l[k];
            in_r[k*DW +: DW] = lane_r[k];
        end
    end

    zc_volume_top #(.DW(DW), .NSRC(NSRC), .SEL_W(SEL_W), .TO_W(TO_W), .ZC_THRESH(THR)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .src_sel(src_sel), .coarse_sel(coarse_sel), .fine_sel(fine_sel),
        .boost_en(boost_en), .mono_en(mono_en), .sw_mute(sw_mute), .zc_en(zc_en),
        .timeout_lim(timeout_lim), .hw_mute(hw_mute), .out_valid(out_valid),
        .out_l(out_l), .out_r(out_r), .zc_status(zc_status)
    );

    int fine_tab   [8] = '{32768, 29205, 26029, 23198, 20675, 18427, 16423, 14637};
    int coarse_tab [8] = '{32768, 13045, 5193, 2068, 823, 328, 130, 52};

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    string tag    = "R12";

    // reference model state
    int m_prev_neg [2];
    int m_flag [2];
    int m_c, m_f, m_m, m_wait, m_status;
    int e_l, e_r, e_v;

    function automatic int level(int x, int f, int c, int b, int m);
        int y;
        y = (x * fine_tab[f]) >>> 15;
        y = (y * coarse_tab[c]) >>> 15;
        if (b != 0) y = y * 2;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        if (m != 0) y = 0;
        return y;
    endfunction

    always @(posedge clk) begin
        int  xs [2];
        int  ys [2];
        int  cr [2];
        int  mg, uc, uf, um, both, pend, cmt;
        if (rst) begin
            m_prev_neg = '{0, 0};
            m_flag = '{0, 0};
            m_c = 0; m_f = 0; m_m = 1; m_wait = 0; m_status = 0;
            e_l = 0; e_r = 0; e_v = 0;
        end else begin
            e_v  = in_valid;
            both = 0;
            if (in_valid) begin
                xs[0] = (src_sel < NSRC) ? int'(lane_l[src_sel]) : 0;
                xs[1] = (src_sel < NSRC) ? int'(lane_r[src_sel]) : 0;
                for (int c = 0; c < 2; c++) begin
                    mg = (xs[c] < 0) ? -xs[c] : xs[c];
                    cr[c] = ((((xs[c] < 0) ? 1 : 0) != m_prev_neg[c]) || mg <= THR) ? 1 : 0;
                end
                both = ((m_flag[0] | cr[0]) & (m_flag[1] | cr[1]));
                pend = (zc_en && (int'(coarse_sel) != m_c || int'(fine_sel) != m_f
                                  || int'(sw_mute) != m_m)) ? 1 : 0;
                cmt  = (pend != 0 && (both != 0 || m_wait >= int'(timeout_lim))) ? 1 : 0;
                if (!zc_en || cmt != 0) begin
                    uc = coarse_sel; uf = fine_sel; um = sw_mute;
                end else begin
                    uc = m_c; uf = m_f; um = m_m;
                end
                for (int c = 0; c < 2; c++) begin
                    ys[c] = level(xs[c], uf, uc, boost_en, um);
                    m_flag[c] = (pend != 0 && cmt == 0) ? (m_flag[c] | cr[c]) : 0;
                    m_prev_neg[c] = (xs[c] < 0) ? 1 : 0;
                end
                m_wait = (pend != 0 && cmt == 0) ? m_wait + 1 : 0;
                m_c = uc; m_f = uf; m_m = um;
                if (mono_en) begin
                    ys[0] = (ys[0] + ys[1]) >>> 1;
                    ys[1] = ys[0];
                end
            end
            if (!zc_en) m_status = 0;
            else if (in_valid && both != 0) m_status = 1;
            if (hw_mute) begin
                e_l = 0; e_r = 0;
            end else if (in_valid) begin
                e_l = ys[0]; e_r = ys[1];
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(out_l) != e_l || int'(out_r) != e_r || int'(out_valid) != e_v
                || int'(zc_status) != m_status) begin
                errors++;
                $display("FAIL %s model: l=%0d r=%0d v=%0d st=%0d expected l=%0d r=%0d v=%0d st=%0d",
                         tag, out_l, out_r, out_valid, zc_status, e_l, e_r, e_v, m_status);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s directed: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < NSRC; k++) begin
            lane_l[k] = '0;
            lane_r[k] = '0;
        end
        repeat (3) tick();
        tag = "R12";
        chk("R12", int'(out_l), 0);
        chk("R12", int'(out_valid), 0);
        chk("R12", int'(zc_status), 0);
        rst = 1'b0;

        // R12: active setting after reset is muted; gated request cannot pass yet
        zc_en = 1; timeout_lim = 12'd4095; in_valid = 1;
        lane_l[0] = 16384; lane_r[0] = 16384;
        tick();
        chk("R12", int'(out_l), 0);

        tag = "R2"; zc_en = 0; fine_sel = 1;
        tick(); chk("R2", int'(out_l), 14602);
        tag = "R3"; fine_sel = 0; coarse_sel = 1;
        tick(); chk("R3", int'(out_r), 6522);
        tag = "R4"; coarse_sel = 0; boost_en = 1;
        lane_l[0] = 30000; lane_r[0] = -30000;
        tick(); chk("R4", int'(out_l), 32767); chk("R4", int'(out_r), -32768);
        boost_en = 0;
        tag = "R1"; src_sel = 3; lane_l[3] = 1234; lane_r[3] = -777;
        tick(); chk("R1", int'(out_l), 1234); chk("R1", int'(out_r), -777);
        src_sel = 6;
        tick(); chk("R1", int'(out_l), 0);
        tag = "R5"; src_sel = 3; mono_en = 1;
        tick(); chk("R5", int'(out_l), 228); chk("R5", int'(out_r), 228);
        mono_en = 0;
        tag = "R6"; sw_mute = 1;
        tick(); chk("R6", int'(out_l), 0);
        sw_mute = 0;
        tick();
        tag = "R11"; in_valid = 0; lane_l[3] = 999;
        tick(); chk("R11", int'(out_l), 1234); chk("R11", int'(out_valid), 0);

        // R8: no crossing, forced commit after timeout
        tag = "R8"; in_valid = 1; src_sel = 0;
        lane_l[0] = 16384; lane_r[0] = 16384;
        tick();
        zc_en = 1; timeout_lim = 5; coarse_sel = 1;
        repeat (5) tick();
        chk("R8", int'(out_l), 16384);
        chk("R9", int'(zc_status), 0);
        tick();
        chk("R8", int'(out_l), 6522);

        // R7: commit only after both channels crossed
        tag = "R7"; timeout_lim = 12'd4095; coarse_sel = 0;
        tick(); chk("R7", int'(out_l), 6522);
        lane_l[0] = -16384;
        tick(); chk("R7", int'(out_r), 6522); chk("R9", int'(zc_status), 0);
        lane_r[0] = -16384;
        tick(); chk("R7", int'(out_l), -16384); chk("R7", int'(out_r), -16384);
        chk("R9", int'(zc_status), 1);
        tag = "R9"; zc_en = 0;
        tick(); chk("R9", int'(zc_status), 0);

        // R7/R8/R9: gated volume changes on crossing waveforms
        tag = "R7"; zc_en = 1;
        for (int i = 0; i < 800; i++) begin
            lane_l[0] = DW'(((i % 16) - 8) * 1500 + 20);
            lane_r[0] = DW'(((i % 11) - 5) * 2500 + 90);
            lane_l[2] = DW'($urandom % 65536);
            lane_r[2] = DW'($urandom % 65536);
            in_valid  = ($urandom % 5) != 0;
            if (i % 13 == 0) begin
                coarse_sel = 3'($urandom % 8);
                fine_sel   = 3'($urandom % 8);
                sw_mute    = ($urandom % 6) == 0;
                src_sel    = ($urandom % 4 == 0) ? 3'd2 : 3'd0;
                timeout_lim = ($urandom % 2 == 0) ? 12'd4095 : TO_W'($urandom % 8);
            end
            if (i % 200 == 150) zc_en = 0;
            if (i % 200 == 160) zc_en = 1;
            tick();
        end

        // R10: hardware mute
        tag = "R10"; zc_en = 0; sw_mute = 0; src_sel = 0; coarse_sel = 0; fine_sel = 0;
        lane_l[0] = 16384; lane_r[0] = 16384; in_valid = 1; hw_mute = 1;
        tick(); chk("R10", int'(out_l), 0);
        in_valid = 0;
        tick(); chk("R10", int'(out_r), 0);
        hw_mute = 0; in_valid = 1;
        tick(); chk("R10", int'(out_l), 16384);
        for (int i = 0; i < 300; i++) begin
            lane_l[0] = DW'($urandom % 65536);
            lane_r[0] = DW'($urandom % 65536);
            hw_mute   = ($urandom % 3) == 0;
            in_valid  = ($urandom % 3) != 0;
            zc_en     = (i % 100) > 50;
            coarse_sel = 3'($urandom % 8);
            tick();
        end
        hw_mute = 0;

        // R1..R6: ungated random traffic
        tag = "R6"; zc_en = 0;
        for (int i = 0; i < 800; i++) begin
            for (int k = 0; k < NSRC; k++) begin
                lane_l[k] = DW'($urandom % 65536);
                lane_r[k] = DW'($urandom % 65536);
            end
            src_sel    = 3'($urandom % 8);
            coarse_sel = 3'($urandom % 8);
            fine_sel   = 3'($urandom % 8);
            boost_en   = ($urandom % 2) == 0;
            mono_en    = ($urandom % 3) == 0;
            sw_mute    = ($urandom % 8) == 0;
            in_valid   = ($urandom % 4) != 0;
            tick();
        end
        finish_run();
    end

endmodule